// File: doc/BRIEF.md
# Flash Chip-Select Segment Decoder

This block keeps one window descriptor per flash chip select and maps a shared flash address window onto the devices behind those selects. Each descriptor holds a start and an end, both counted in 8 MB units. Software writes a descriptor through a simple register port. The block then applies the fixed limits: the first select always starts at the window base, and in one build option the last select keeps a fixed end. It also checks the new window against the overall flash window, its own size and the other selects, and records the result in three flags. A flagged write is still stored.

On the access side, a bus address is matched against every window. The lowest-numbered select whose window contains the address wins, and the block returns a one-hot select and the offset into that device. A second path takes a select number and a device-relative offset and folds the offset back into that select's segment. This fold assumes power-of-two segment sizes.

Top module: `fseg_decoder`

## Requirements
- R1: A descriptor reads back as end in bits [31:24] and start in bits [23:16], both in 8 MB units (address bits 30..23). Bits [15:0] always read zero, and a read of a select number at or above NUM_CS returns zero.
- R2: After reset, select 0 spans start 0x40 to end 0x48 (64 MB at the window base). Selects 1 to 4 follow back to back with 32 MB each (0x48-0x4C, 0x4C-0x50, 0x50-0x54, 0x54-0x58). All three flags are 0.
- R3: A write to select 0 always stores the start as the window base (0x40), and the end field of the same write is still stored.
- R4: With LOCK_LAST_END set, a write to the last select always stores its reset end (0x58), and its start field is still stored.
- R5: err_range is set by a changed write whose end is at or below the window base (0x40), or whose start is above the window base plus WIN_UNITS (0x60). The value is stored anyway.
- R6: err_align is set by a changed write whose size (end minus start) is nonzero and does not divide its start. A zero size never sets it.
- R7: warn_overlap is set by a changed write to select k when, for some other select j, the new start is below j's end and the new end is above j's start. The value is stored anyway.
- R8: A write whose bits [31:16] equal the stored descriptor leaves all three flags unchanged. A write to a select number at or above NUM_CS changes no descriptor and no flag.
- R9: The flags take the check results of a changed write at the clock edge that stores it, and hold them until the next changed write.
- R10: An address with bit 31 clear and address bits 30..23 in [start, end) of a select matches that select. hit_cs is one-hot on the lowest matching select, and hit_offset is the address minus start*8 MB. With no match, hit_cs, hit_any and hit_offset are all zero.
- R11: acc_wrapped is acc_off modulo the size in bytes of select acc_cs. It is zero when that size is zero or acc_cs is at or above NUM_CS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Descriptor write strobe |
| cfg_sel | input | SEL_W | Select number written |
| cfg_wdata | input | 32 | Write data (end [31:24], start [23:16]) |
| rd_sel | input | SEL_W | Select number read |
| rd_data | output | 32 | Descriptor of rd_sel |
| bus_addr | input | 32 | Address presented to the flash window |
| hit_cs | output | NUM_CS | One-hot owning select |
| hit_any | output | 1 | Some select owns bus_addr |
| hit_offset | output | 32 | Offset of bus_addr inside the owning window |
| acc_cs | input | SEL_W | Select of a device-relative access |
| acc_off | input | 32 | Device-relative offset |
| acc_wrapped | output | 32 | Offset folded into the segment |
| err_range | output | 1 | Last changed write lies outside the flash window |
| err_align | output | 1 | Last changed write is misaligned |
| warn_overlap | output | 1 | Last changed write overlaps another select |

## Verification
A wrong stored start or end shows at rd_data as soon as that select is read, and at hit_cs and hit_offset for any address near that window's edge in the same cycle. A wrong correction for select 0 or the last select appears one edge after the write. A check that runs when it should not shows as a flag changing one edge after a repeated write. Overlapping windows are set up on purpose, so a broken priority shows as the wrong one-hot bit.

// File: rtl/fseg_pkg.sv
package fseg_pkg;

  // One window descriptor in 8 MB units: lim is the exclusive end.
  typedef struct packed {
    logic [7:0] lim;
    logic [7:0] base;
  } seg_t;

  function automatic logic [7:0] seg_units(seg_t s);
    return s.lim - s.base;
  endfunction

  function automatic logic [31:0] units_to_bytes(logic [7:0] u);
    return {1'b0, u, 23'b0};
  endfunction

  // Nonzero size that does not divide the start.
  function automatic logic misaligned(seg_t s);
    logic [7:0] sz;
    sz = seg_units(s);
    if (sz == 8'd0) return 1'b0;
    return (s.base % sz) != 8'd0;
  endfunction

  // Reset placement: first window u0 units, the rest un units, back to back.
  function automatic seg_t default_seg(int idx, logic [7:0] base_u, int u0, int un);
    seg_t s;
    int st;
    st = (idx == 0) ? 0 : u0 + (idx - 1) * un;
    s.base = base_u + 8'(st);
    s.lim  = s.base + 8'((idx == 0) ? u0 : un);
    return s;
  endfunction

endpackage

// File: rtl/fseg_write_check.sv
module fseg_write_check
  import fseg_pkg::*;
#(
  parameter int         NUM_CS        = 5,
  parameter int         SEL_W         = 3,
  parameter logic [7:0] WIN_BASE_U    = 8'h40,
  parameter logic [7:0] WIN_UNITS     = 8'd32,
  parameter bit         LOCK_LAST_END = 1'b0,
  parameter logic [7:0] LAST_END      = 8'h58
) (
  input  logic [SEL_W-1:0]  cs_idx,
  input  seg_t              req,
  input  seg_t [NUM_CS-1:0] segs,
  output seg_t              fixed,
  output logic              bad_range,
  output logic              bad_align,
  output logic              overlap
);

  localparam logic [8:0] WIN_TOP_U = {1'b0, WIN_BASE_U} + {1'b0, WIN_UNITS};
  localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_CS - 1);

  always_comb begin
    fixed = req;
    if (cs_idx == '0) fixed.base = WIN_BASE_U;
    if (LOCK_LAST_END && cs_idx == LAST_IDX) fixed.lim = LAST_END;
  end

  always_comb begin
    bad_range = (fixed.lim <= WIN_BASE_U) || ({1'b0, fixed.base} > WIN_TOP_U);
    bad_align = misaligned(fixed);
  end

  always_comb begin
    overlap = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (SEL_W'(i) != cs_idx &&
          fixed.base < segs[i].lim && fixed.lim > segs[i].base)
        overlap = 1'b1;
    end
  end

endmodule

// File: rtl/fseg_addr_match.sv
module fseg_addr_match
  import fseg_pkg::*;
#(
  parameter int NUM_CS = 5
) (
  input  seg_t [NUM_CS-1:0] segs,
  input  logic [31:0]       addr,
  output logic [NUM_CS-1:0] match_raw,
  output logic [NUM_CS-1:0] hit_onehot,
  output logic [31:0]       offset
);

  logic [7:0] addr_u;
  assign addr_u = addr[30:23];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    assign match_raw[g] = !addr[31] && addr_u >= segs[g].base && addr_u < segs[g].lim;
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    hit_onehot = '0;
    offset     = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (match_raw[i] && !found) begin
        found         = 1'b1;
        hit_onehot[i] = 1'b1;
        offset        = addr - units_to_bytes(segs[i].base);
      end
    end
  end

endmodule

// File: rtl/fseg_decoder.sv
module fseg_decoder
  import fseg_pkg::*;
#(
  parameter int         NUM_CS        = 5,
  parameter logic [7:0] WIN_BASE_U    = 8'h40,
  parameter logic [7:0] WIN_UNITS     = 8'd32,
  parameter int         FIRST_UNITS   = 8,
  parameter int         OTHER_UNITS   = 4,
  parameter bit         LOCK_LAST_END = 1'b0,
  localparam int        SEL_W         = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [31:0]       rd_data,
  input  logic [31:0]       bus_addr,
  output logic [NUM_CS-1:0] hit_cs,
  output logic              hit_any,
  output logic [31:0]       hit_offset,
  input  logic [SEL_W-1:0]  acc_cs,
  input  logic [31:0]       acc_off,
  output logic [31:0]       acc_wrapped,
  output logic              err_range,
  output logic              err_align,
  output logic              warn_overlap
);

  localparam logic [SEL_W:0] NCS = (SEL_W + 1)'(NUM_CS);
  localparam seg_t LAST_DEF = default_seg(NUM_CS - 1, WIN_BASE_U, FIRST_UNITS, OTHER_UNITS);

  seg_t [NUM_CS-1:0] seg_q;

  // Internal events brought out by name for the checker.
  logic        wr_valid;
  logic        wr_changed;
  seg_t        wr_req;
  seg_t        wr_cur;
  seg_t        wr_fixed;
  logic        chk_range, chk_align, chk_overlap;
  logic [NUM_CS-1:0] match_raw;
  logic        unused_low;

  assign unused_low = ^cfg_wdata[15:0];

  assign wr_valid   = cfg_wr && ({1'b0, cfg_sel} < NCS);
  assign wr_req     = seg_t'(cfg_wdata[31:16]);
  assign wr_cur     = ({1'b0, cfg_sel} < NCS) ? seg_q[cfg_sel] : '0;
  assign wr_changed = wr_valid && (wr_req != wr_cur);

  fseg_write_check #(
    .NUM_CS       (NUM_CS),
    .SEL_W        (SEL_W),
    .WIN_BASE_U   (WIN_BASE_U),
    .WIN_UNITS    (WIN_UNITS),
    .LOCK_LAST_END(LOCK_LAST_END),
    .LAST_END     (LAST_DEF.lim)
  ) u_check (
    .cs_idx   (cfg_sel),
    .req      (wr_req),
    .segs     (seg_q),
    .fixed    (wr_fixed),
    .bad_range(chk_range),
    .bad_align(chk_align),
    .overlap  (chk_overlap)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
    localparam seg_t DEF = default_seg(g, WIN_BASE_U, FIRST_UNITS, OTHER_UNITS);
    always_ff @(posedge clk) begin
      if (!rst_n)
        seg_q[g] <= DEF;
      else if (wr_changed && cfg_sel == SEL_W'(g))
        seg_q[g] <= wr_fixed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_range    <= 1'b0;
      err_align    <= 1'b0;
      warn_overlap <= 1'b0;
    end else if (wr_changed) begin
      err_range    <= chk_range;
      err_align    <= chk_align;
      warn_overlap <= chk_overlap;
    end
  end

  assign rd_data = ({1'b0, rd_sel} < NCS) ? {seg_q[rd_sel], 16'h0000} : 32'h0;

  fseg_addr_match #(
    .NUM_CS(NUM_CS)
  ) u_match (
    .segs      (seg_q),
    .addr      (bus_addr),
    .match_raw (match_raw),
    .hit_onehot(hit_cs),
    .offset    (hit_offset)
  );

  assign hit_any = |hit_cs;

  // Offset folding inside a power-of-two segment.
  always_comb begin
    logic [7:0]  sz;
    logic [31:0] bytes;
    sz    = ({1'b0, acc_cs} < NCS) ? seg_units(seg_q[acc_cs]) : 8'd0;
    bytes = units_to_bytes(sz);
    acc_wrapped = (sz == 8'd0) ? 32'h0 : (acc_off & (bytes - 32'd1));
  end

endmodule

// File: rtl/fseg_decoder_chk.sv
module fseg_decoder_chk
  import fseg_pkg::*;
#(
  parameter int         NUM_CS        = 5,
  parameter int         SEL_W         = 3,
  parameter logic [7:0] WIN_BASE_U    = 8'h40,
  parameter bit         LOCK_LAST_END = 1'b0,
  parameter logic [7:0] LAST_END      = 8'h58
) (
  input logic              clk,
  input logic              rst_n,
  input seg_t [NUM_CS-1:0] seg_q,
  input logic [NUM_CS-1:0] match_raw,
  input logic [NUM_CS-1:0] hit_cs,
  input logic              hit_any,
  input logic              cfg_wr,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [31:0]       cfg_wdata,
  input logic [SEL_W-1:0]  acc_cs,
  input logic [31:0]       acc_wrapped,
  input logic              err_range,
  input logic              err_align,
  input logic              warn_overlap
);

  localparam logic [SEL_W:0] NCS = (SEL_W + 1)'(NUM_CS);

  logic        same_write;
  logic [31:0] acc_bytes;
  assign same_write = cfg_wr && ({1'b0, cfg_sel} < NCS) &&
                      (cfg_wdata[31:16] == (({1'b0, cfg_sel} < NCS) ? seg_q[cfg_sel] : 16'h0));
  assign acc_bytes  = ({1'b0, acc_cs} < NCS) ? units_to_bytes(seg_units(seg_q[acc_cs])) : 32'h0;

  p_cs0_base_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_q[0].base == WIN_BASE_U);

  p_last_end_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    LOCK_LAST_END |-> seg_q[NUM_CS-1].lim == LAST_END);

  p_quiet_rewrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    same_write |=> $stable({err_range, err_align, warn_overlap}));

  p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_cs) && (hit_any == (|match_raw)));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_prio
    localparam logic [NUM_CS-1:0] LOWER = NUM_CS'((64'd1 << g) - 64'd1);
    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cs[g] |-> (match_raw[g] && (match_raw & LOWER) == '0));
  end

  p_wrap_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_bytes != 32'h0) |-> (acc_wrapped < acc_bytes));

endmodule

bind fseg_decoder fseg_decoder_chk #(
  .NUM_CS       (NUM_CS),
  .SEL_W        (SEL_W),
  .WIN_BASE_U   (WIN_BASE_U),
  .LOCK_LAST_END(LOCK_LAST_END),
  .LAST_END     (LAST_DEF.lim)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seg_q       (seg_q),
  .match_raw   (match_raw),
  .hit_cs      (hit_cs),
  .hit_any     (hit_any),
  .cfg_wr      (cfg_wr),
  .cfg_sel     (cfg_sel),
  .cfg_wdata   (cfg_wdata),
  .acc_cs      (acc_cs),
  .acc_wrapped (acc_wrapped),
  .err_range   (err_range),
  .err_align   (err_align),
  .warn_overlap(warn_overlap)
);

// File: tb/fseg_decoder_tb.sv
`timescale 1ns/1ps
module fseg_decoder_tb;

  localparam int NCS = 5;
  localparam int SW  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_wr = 1'b0;
  logic [SW-1:0]   cfg_sel = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [SW-1:0]   rd_sel = '0;
  logic [31:0]     rd_data;
  logic [31:0]     bus_addr = '0;
  logic [NCS-1:0]  hit_cs;
  logic            hit_any;
  logic [31:0]     hit_offset;
  logic [SW-1:0]   acc_cs = '0;
  logic [31:0]     acc_off = '0;
  logic [31:0]     acc_wrapped;
  logic            err_range, err_align, warn_overlap;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fseg_decoder #(.NUM_CS(NCS), .LOCK_LAST_END(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .bus_addr(bus_addr), .hit_cs(hit_cs), .hit_any(hit_any),
    .hit_offset(hit_offset), .acc_cs(acc_cs), .acc_off(acc_off),
    .acc_wrapped(acc_wrapped), .err_range(err_range),
    .err_align(err_align), .warn_overlap(warn_overlap)
  );

  // {sel, write data, expected read-back, expected {range,align,overlap}}
  localparam int NV = 9;
  localparam logic [69:0] VEC [NV] = '{
    {3'd1, 32'h5048_0000, 32'h5048_0000, 3'b001},  // R7 overlap with cs2
    {3'd1, 32'h4C48_ABCD, 32'h4C48_0000, 3'b000},  // R1 low bits dropped
    {3'd2, 32'h524E_0000, 32'h524E_0000, 3'b011},  // R6 misaligned + R7
    {3'd2, 32'h524E_1234, 32'h524E_0000, 3'b011},  // R8 unchanged: flags hold
    {3'd3, 32'h7068_0000, 32'h7068_0000, 3'b100},  // R5 start above window
    {3'd0, 32'h4430_0000, 32'h4440_0000, 3'b000},  // R3 start forced to base
    {3'd4, 32'h6056_0000, 32'h5856_0000, 3'b000},  // R4 end forced back
    {3'd1, 32'h3F38_0000, 32'h3F38_0000, 3'b100},  // R5 end below window
    {3'd5, 32'h1234_0000, 32'h0000_0000, 3'b100}   // R8 out-of-range select
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [SW-1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic look(logic [31:0] a, logic [NCS-1:0] exp_cs, logic [31:0] exp_off);
    bus_addr = a;
    #1;
    chk("R10 hit_cs", 32'(hit_cs), 32'(exp_cs));
    chk("R10 hit_any", 32'(hit_any), 32'(exp_cs != '0));
    chk("R10 hit_offset", hit_offset, exp_off);
  endtask

  task automatic fold(logic [SW-1:0] c, logic [31:0] off, logic [31:0] exp);
    acc_cs = c; acc_off = off;
    #1;
    chk("R11 acc_wrapped", acc_wrapped, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] defs [NCS];
    defs = '{32'h4840_0000, 32'h4C48_0000, 32'h504C_0000, 32'h5450_0000, 32'h5854_0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset defaults and flags
    for (int i = 0; i < NCS; i++) begin
      rd_sel = SW'(i); #1;
      chk("R2 default window", rd_data, defs[i]);
    end
    chk("R2 reset flags", {29'd0, err_range, err_align, warn_overlap}, 32'd0);

    // Table of writes; flags and stored value appear after the write edge (R9)
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][69:67], VEC[v][66:35]);
      rd_sel = VEC[v][69:67]; #1;
      chk("R1 R3 R4 read-back", rd_data, VEC[v][34:3]);
      chk("R5 R6 R7 R9 flags", {29'd0, err_range, err_align, warn_overlap},
          {29'd0, VEC[v][2:0]});
    end

    // State now: cs0 40-44, cs1 38-3F, cs2 4E-52, cs3 68-70, cs4 56-58
    look(32'h2000_0100, 5'b00001, 32'h0000_0100);  // R10 cs0
    look(32'h2780_0010, 5'b00100, 32'h0080_0010);  // R10 cs2
    look(32'h2B80_0004, 5'b10000, 32'h0080_0004);  // R10 cs4
    look(32'h2300_0000, 5'b00000, 32'h0000_0000);  // R10 gap
    look(32'hA000_0100, 5'b00000, 32'h0000_0000);  // R10 bit 31 set

    fold(3'd2, 32'h0200_0010, 32'h0000_0010);      // R11 32 MB
    fold(3'd3, 32'h0412_3456, 32'h0012_3456);      // R11 64 MB
    fold(3'd4, 32'h00FF_FFFF, 32'h00FF_FFFF);      // R11 16 MB, in range
    fold(3'd6, 32'h0000_1234, 32'h0000_0000);      // R11 bad select

    // R10 priority with overlapping windows cs0 40-44, cs1 40-48
    wr(3'd1, 32'h4840_0000);
    chk("R7 overlap accepted", {29'd0, err_range, err_align, warn_overlap}, 32'd1);
    rd_sel = 3'd1; #1;
    chk("R7 value stored", rd_data, 32'h4840_0000);
    look(32'h2080_0000, 5'b00001, 32'h0080_0000);  // R10 lowest wins
    look(32'h2280_0000, 5'b00010, 32'h0280_0000);  // R10 cs1 beyond cs0

    // Zero-size window: R6 no align flag, R5 range, R11 folds to zero
    wr(3'd3, 32'h6868_0000);
    chk("R5 R6 zero size flags", {29'd0, err_range, err_align, warn_overlap}, 32'd4);
    fold(3'd3, 32'h0000_1234, 32'h0000_0000);
    look(32'h3400_0000, 5'b00000, 32'h0000_0000);  // R10 empty window

    done = 1'b1;
    summary();
  end

endmodule